// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home-node side of an MSI directory protocol for a small set of cache lines. Caching nodes send it read requests (Get-S), write-permission requests (Get-M) and dirty writebacks (Put-M). Each request carries the requester id, the line index and, for writebacks, the line data. The controller keeps one directory entry per line. An entry holds a stable state (I, S or M), an owner pointer and a sharer bit vector. The controller also keeps the line data, which it reads with a fixed latency.

For every request it accepts, the controller emits exactly one outgoing message beat. The beat is one of four kinds. Data goes to the requester and can carry a multicast Invalidate mask together with the matching ack count. Fwd-Get-S and Fwd-Get-M go to the current owner and name the requester. Put-Ack goes to the node that wrote the line back. A Get-S to a modified line is forwarded to the owner, giving a 3-hop read. The line then waits in a transient state until the owner's copy of the data comes back on a separate owner-data input. Two races are absorbed without extra messages: a writeback that crosses a forwarded read, and a writeback from a node that has already lost ownership.

All three message interfaces use valid/ready handshakes. A message beat is offered on `out_valid` and must stay unchanged until `out_ready` is seen high at a clock edge. While a beat is waiting, no request and no owner data is accepted. When both inputs are valid in the same cycle, owner data takes priority over a request. A request that cannot be served yet keeps `req_ready` low. The sender must hold it until it is taken.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every line is in I with no sharers and line data zero; `req_ready` and `odat_ready` are high and `out_valid` is low.
- R2: A Get-S (req_type 0; code 3 is treated as Get-S) to a line in I or S is answered with a Data beat (out_kind 0) to the requester, carrying the stored line data and ack count 0. The requester is added to the sharers and the line becomes S.
- R3: A Data beat appears exactly MEM_LAT cycles after the accepting clock edge. Forward and Put-Ack beats appear on the edge that accepts the request.
- R4: A Get-M (req_type 1) to a line in I or S returns Data whose invalidate mask is the sharer vector with the requester's bit cleared. Its ack count is the number of bits set in that mask (0 for a line in I). The line becomes M with the requester as owner.
- R5: A Get-M to a line in M sends Fwd-Get-M (out_kind 2) to the current owner, with out_req set to the requester. The owner pointer moves to the requester at once, so a second Get-M is forwarded to the first requester.
- R6: A Get-S to a line in M sends Fwd-Get-S (out_kind 1) to the owner, with out_req set to the requester. The line enters the transient state. Owner data for that line then writes memory, and the line becomes S with both the old owner and the requester as sharers.
- R7: A Put-M (req_type 2) from the owner of a line in M writes its data, leaves the line in I with no owner, and returns Put-Ack (out_kind 3) to the sender.
- R8: A Put-M from a node that is not the owner of a line in M is answered with Put-Ack. The line data and the directory entry are left unchanged.
- R9: A Put-M to a line in the transient state from a listed sharer writes its data, settles the line in S, and returns Put-Ack. Owner data arriving later for a line that is no longer transient is consumed and ignored.
- R10: Any request other than Put-M to a line in the transient state is held with `req_ready` low. Owner data is still accepted during the hold and releases it.
- R11: While `out_valid` is high and `out_ready` is low, every output field stays unchanged. While a beat is pending, both `req_ready` and `odat_ready` are low.
- R12: A Data beat never names its own destination in the invalidate mask. Non-Data beats carry an empty mask and zero acks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request beat offered |
| req_ready | output | 1 | Request beat taken this edge |
| req_type | input | 2 | 0 Get-S, 1 Get-M, 2 Put-M, 3 treated as Get-S |
| req_src | input | log2(NODES) | Requesting node id |
| req_line | input | log2(LINES) | Line index |
| req_data | input | DW | Writeback data (Put-M) |
| odat_valid | input | 1 | Owner data returned after a forwarded read |
| odat_ready | output | 1 | Owner data taken this edge |
| odat_line | input | log2(LINES) | Line of the owner data |
| odat_data | input | DW | Owner data value |
| out_valid | output | 1 | Message beat offered |
| out_ready | input | 1 | Message beat taken this edge |
| out_kind | output | 2 | 0 Data, 1 Fwd-Get-S, 2 Fwd-Get-M, 3 Put-Ack |
| out_dst | output | log2(NODES) | Destination node |
| out_req | output | log2(NODES) | Original requester (for forwards) |
| out_line | output | log2(LINES) | Line index |
| out_data | output | DW | Line data (Data beats, zero otherwise) |
| out_inv | output | NODES | Nodes that receive Invalidate with this Data |
| out_acks | output | log2(NODES+1) | Ack count the requester must collect |

## Verification
A corrupted sharer vector shows up on the next Get-M to that line, as a wrong invalidate mask and ack count in the Data beat. A stale owner pointer shows up on the next forward, as the wrong out_dst. Both are checked by sweeping every sharer subset against every requester. A wrong transient state shows up in the very next cycle, as `req_ready` being held or released at the wrong time. Lost or misplaced writeback data is seen on the following Get-S, within one transaction. Latency errors are caught by counting the cycles to `out_valid` on every beat.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_M = 2'd2, LS_SD = 2'd3} line_st_e;
  typedef enum logic [1:0] {RQ_GETS = 2'd0, RQ_GETM = 2'd1, RQ_PUTM = 2'd2, RQ_RSVD = 2'd3} req_e;
  typedef enum logic [1:0] {MK_DATA = 2'd0, MK_FWDS = 2'd1, MK_FWDM = 2'd2, MK_PUTACK = 2'd3} msg_e;
endpackage

// File: rtl/dir_table.sv
module dir_table
  import dir_pkg::*;
#(
  parameter int NODES = 4,
  parameter int LINES = 4,
  localparam int NW = $clog2(NODES),
  localparam int LW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LW-1:0]    ra_idx,
  output line_st_e         ra_st,
  output logic [NW-1:0]    ra_own,
  output logic [NODES-1:0] ra_shr,
  input  logic [LW-1:0]    rb_idx,
  output line_st_e         rb_st,
  output logic [NW-1:0]    rb_own,
  output logic [NODES-1:0] rb_shr,
  input  logic             we,
  input  logic [LW-1:0]    w_idx,
  input  line_st_e         w_st,
  input  logic [NW-1:0]    w_own,
  input  logic [NODES-1:0] w_shr
);
  line_st_e         st_q  [LINES];
  logic [NW-1:0]    own_q [LINES];
  logic [NODES-1:0] shr_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= LS_I;
        own_q[i] <= '0;
        shr_q[i] <= '0;
      end
    end else if (we) begin
      st_q[w_idx]  <= w_st;
      own_q[w_idx] <= w_own;
      shr_q[w_idx] <= w_shr;
    end
  end

  assign ra_st  = st_q[ra_idx];
  assign ra_own = own_q[ra_idx];
  assign ra_shr = shr_q[ra_idx];
  assign rb_st  = st_q[rb_idx];
  assign rb_own = own_q[rb_idx];
  assign rb_shr = shr_q[rb_idx];
endmodule

// File: rtl/dir_mem.sv
module dir_mem #(
  parameter int LINES = 4,
  parameter int DW = 8,
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic          we,
  input  logic [LW-1:0] w_idx,
  input  logic [DW-1:0] w_data
);
  logic [DW-1:0] mem_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[w_idx] <= w_data;
    end
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/dir_out_stage.sv
module dir_out_stage #(
  parameter int NODES = 4,
  parameter int LINES = 4,
  parameter int DW = 8,
  parameter int LAT = 2,
  localparam int NW = $clog2(NODES),
  localparam int LW = $clog2(LINES),
  localparam int AW = $clog2(NODES + 1),
  localparam int CW = $clog2(LAT + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             l_slow,
  input  logic [1:0]       l_kind,
  input  logic [NW-1:0]    l_dst,
  input  logic [NW-1:0]    l_req,
  input  logic [LW-1:0]    l_line,
  input  logic [DW-1:0]    l_data,
  input  logic [NODES-1:0] l_inv,
  input  logic [AW-1:0]    l_acks,
  output logic             busy,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_kind,
  output logic [NW-1:0]    out_dst,
  output logic [NW-1:0]    out_req,
  output logic [LW-1:0]    out_line,
  output logic [DW-1:0]    out_data,
  output logic [NODES-1:0] out_inv,
  output logic [AW-1:0]    out_acks
);
  logic          full_q;
  logic [CW-1:0] cnt_q;

  assign busy      = full_q;
  assign out_valid = full_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q   <= 1'b0;
      cnt_q    <= '0;
      out_kind <= '0;
      out_dst  <= '0;
      out_req  <= '0;
      out_line <= '0;
      out_data <= '0;
      out_inv  <= '0;
      out_acks <= '0;
    end else if (load) begin
      full_q   <= 1'b1;
      cnt_q    <= l_slow ? CW'(LAT) : '0;
      out_kind <= l_kind;
      out_dst  <= l_dst;
      out_req  <= l_req;
      out_line <= l_line;
      out_data <= l_data;
      out_inv  <= l_inv;
      out_acks <= l_acks;
    end else if (full_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (out_valid && out_ready) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NODES = 4,
  parameter int LINES = 4,
  parameter int DW = 8,
  parameter int MEM_LAT = 2,
  localparam int NW = $clog2(NODES),
  localparam int LW = $clog2(LINES),
  localparam int AW = $clog2(NODES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_type,
  input  logic [NW-1:0]    req_src,
  input  logic [LW-1:0]    req_line,
  input  logic [DW-1:0]    req_data,
  input  logic             odat_valid,
  output logic             odat_ready,
  input  logic [LW-1:0]    odat_line,
  input  logic [DW-1:0]    odat_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_kind,
  output logic [NW-1:0]    out_dst,
  output logic [NW-1:0]    out_req,
  output logic [LW-1:0]    out_line,
  output logic [DW-1:0]    out_data,
  output logic [NODES-1:0] out_inv,
  output logic [AW-1:0]    out_acks
);
  line_st_e         ea_st, eb_st, w_st;
  logic [NW-1:0]    ea_own, eb_own, w_own;
  logic [NODES-1:0] ea_shr, eb_shr, w_shr;
  logic             t_we, m_we, busy;
  logic [LW-1:0]    w_idx, m_idx;
  logic [DW-1:0]    m_data, rd_data;
  logic             load, l_slow;
  logic [1:0]       l_kind;
  logic [NW-1:0]    l_dst;
  logic [NODES-1:0] l_inv;
  logic [AW-1:0]    l_acks;
  logic [DW-1:0]    l_data;
  logic [NODES-1:0] src_bit, own_bit;
  logic             hold, od_take, rq_take;

  dir_table #(.NODES(NODES), .LINES(LINES)) u_table (
    .clk, .rst_n,
    .ra_idx(req_line), .ra_st(ea_st), .ra_own(ea_own), .ra_shr(ea_shr),
    .rb_idx(odat_line), .rb_st(eb_st), .rb_own(eb_own), .rb_shr(eb_shr),
    .we(t_we), .w_idx(w_idx), .w_st(w_st), .w_own(w_own), .w_shr(w_shr)
  );

  dir_mem #(.LINES(LINES), .DW(DW)) u_mem (
    .clk, .rst_n, .rd_idx(req_line), .rd_data(rd_data),
    .we(m_we), .w_idx(m_idx), .w_data(m_data)
  );

  dir_out_stage #(.NODES(NODES), .LINES(LINES), .DW(DW), .LAT(MEM_LAT)) u_out (
    .clk, .rst_n, .load, .l_slow, .l_kind, .l_dst, .l_req(req_src),
    .l_line(req_line), .l_data, .l_inv, .l_acks, .busy,
    .out_valid, .out_ready, .out_kind, .out_dst, .out_req, .out_line,
    .out_data, .out_inv, .out_acks
  );

  // A transient line blocks everything except the writeback that resolves it.
  assign hold       = (ea_st == LS_SD) && (req_type != RQ_PUTM);
  assign odat_ready = !busy;
  assign req_ready  = !busy && !odat_valid && !hold;
  assign od_take    = odat_valid && odat_ready;
  assign rq_take    = req_valid && req_ready;
  assign src_bit    = NODES'(1) << req_src;
  assign own_bit    = NODES'(1) << ea_own;

  always_comb begin
    t_we   = 1'b0;
    w_idx  = req_line;
    w_st   = ea_st;
    w_own  = ea_own;
    w_shr  = ea_shr;
    m_we   = 1'b0;
    m_idx  = req_line;
    m_data = req_data;
    load   = 1'b0;
    l_slow = 1'b0;
    l_kind = MK_DATA;
    l_dst  = req_src;
    l_inv  = '0;
    l_acks = '0;
    l_data = '0;
    if (od_take) begin
      // Owner data only matters while the line still waits for it.
      if (eb_st == LS_SD) begin
        t_we   = 1'b1;
        w_idx  = odat_line;
        w_st   = LS_S;
        w_own  = eb_own;
        w_shr  = eb_shr;
        m_we   = 1'b1;
        m_idx  = odat_line;
        m_data = odat_data;
      end
    end else if (rq_take) begin
      load = 1'b1;
      if (req_type == RQ_PUTM) begin
        l_kind = MK_PUTACK;
        if (ea_st == LS_M && ea_own == req_src) begin
          t_we  = 1'b1;
          w_st  = LS_I;
          w_own = '0;
          w_shr = '0;
          m_we  = 1'b1;
        end else if (ea_st == LS_SD && ea_shr[req_src]) begin
          t_we = 1'b1;
          w_st = LS_S;
          m_we = 1'b1;
        end
      end else if (req_type == RQ_GETM) begin
        t_we  = 1'b1;
        w_own = req_src;
        if (ea_st == LS_M) begin
          l_kind = MK_FWDM;
          l_dst  = ea_own;
        end else begin
          l_slow = 1'b1;
          l_data = rd_data;
          l_inv  = (ea_st == LS_S) ? (ea_shr & ~src_bit) : '0;
          l_acks = AW'($countones(l_inv));
          w_st   = LS_M;
          w_shr  = '0;
        end
      end else begin
        t_we = 1'b1;
        if (ea_st == LS_M) begin
          l_kind = MK_FWDS;
          l_dst  = ea_own;
          w_st   = LS_SD;
          w_shr  = own_bit | src_bit;
        end else begin
          l_slow = 1'b1;
          l_data = rd_data;
          w_st   = LS_S;
          w_shr  = ea_shr | src_bit;
        end
      end
    end
  end
endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
  parameter int NODES = 4,
  parameter int LINES = 4,
  parameter int DW = 8,
  localparam int NW = $clog2(NODES),
  localparam int LW = $clog2(LINES),
  localparam int AW = $clog2(NODES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             odat_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [1:0]       out_kind,
  input logic [NW-1:0]    out_dst,
  input logic [NW-1:0]    out_req,
  input logic [LW-1:0]    out_line,
  input logic [DW-1:0]    out_data,
  input logic [NODES-1:0] out_inv,
  input logic [AW-1:0]    out_acks
);
  a_r11_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_dst)
      && $stable(out_req) && $stable(out_line) && $stable(out_data)
      && $stable(out_inv) && $stable(out_acks));

  a_r11_no_req_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready && !odat_ready);

  a_r12_inv_not_dst: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_inv[out_dst]);

  a_r12_nondata_clean: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind != 2'd0 |-> out_inv == '0 && out_acks == '0 && out_data == '0);

  a_r4_acks_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_acks <= AW'(NODES - 1));
endmodule

bind dir_home_ctrl dir_home_chk #(.NODES(NODES), .LINES(LINES), .DW(DW)) u_chk (
  .clk, .rst_n, .req_ready, .odat_ready, .out_valid, .out_ready, .out_kind,
  .out_dst, .out_req, .out_line, .out_data, .out_inv, .out_acks
);

// File: tb/tb_dir_home_ctrl.sv
module tb_dir_home_ctrl;
  localparam int NODES = 4, LINES = 4, DW = 8, LAT = 2;
  localparam int K_DATA = 0, K_FWDS = 1, K_FWDM = 2, K_ACK = 3;
  localparam int T_GETS = 0, T_GETM = 1, T_PUTM = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, odat_valid = 0, out_ready = 0;
  logic [1:0] req_type = 0;
  logic [1:0] req_src = 0, req_line = 0, odat_line = 0;
  logic [7:0] req_data = 0, odat_data = 0;
  logic req_ready, odat_ready, out_valid;
  logic [1:0] out_kind, out_dst, out_req, out_line;
  logic [7:0] out_data;
  logic [3:0] out_inv;
  logic [2:0] out_acks;
  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  dir_home_ctrl #(.NODES(NODES), .LINES(LINES), .DW(DW), .MEM_LAT(LAT)) dut (.*);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic send(input int t, input int src, input int line, input int d);
    @(negedge clk);
    req_valid = 1; req_type = 2'(t); req_src = 2'(src); req_line = 2'(line); req_data = 8'(d);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic owner_data(input int line, input int d);
    @(negedge clk);
    odat_valid = 1; odat_line = 2'(line); odat_data = 8'(d);
    #1;
    while (!odat_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    odat_valid = 0;
  endtask

  // Waits for the beat, checks latency, fields and stall stability, then takes it.
  task automatic expect_msg(input string rq, input int kind, input int dst, input int rid,
                            input int line, input int d, input int inv, input int acks);
    int n = 0;
    @(negedge clk);
    while (!out_valid && n < 50) begin n++; @(negedge clk); end
    chk(n == ((kind == K_DATA) ? LAT : 0), {rq, " R3 latency"}, n, (kind == K_DATA) ? LAT : 0);
    for (int s = 0; s < 2; s++) begin
      chk(out_valid && int'(out_kind) == kind, {rq, " kind"}, int'(out_kind), kind);
      chk(int'(out_dst) == dst, {rq, " dst"}, int'(out_dst), dst);
      chk(int'(out_line) == line, {rq, " line"}, int'(out_line), line);
      if (kind == K_FWDS || kind == K_FWDM) chk(int'(out_req) == rid, {rq, " req"}, int'(out_req), rid);
      if (kind == K_DATA) begin
        chk(int'(out_data) == d, {rq, " data"}, int'(out_data), d);
        chk(int'(out_inv) == inv, {rq, " inv"}, int'(out_inv), inv);
        chk(int'(out_acks) == acks, {rq, " acks"}, int'(out_acks), acks);
      end
      // R11: stalled for one extra cycle before taking the beat
      if (s == 0) @(negedge clk);
    end
    out_ready = 1;
    @(posedge clk); #1;
    out_ready = 0;
  endtask

  initial begin
    int mem0 = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: reset state at the ports
    chk(req_ready == 1, "R1 req_ready", int'(req_ready), 1);
    chk(odat_ready == 1, "R1 odat_ready", int'(odat_ready), 1);
    chk(out_valid == 0, "R1 out_valid", int'(out_valid), 0);

    // R2 R4 R7: sweep every sharer set against every Get-M requester on line 0
    for (int m = 1; m < 16; m++) begin
      for (int r = 0; r < 4; r++) begin
        int inv, cnt;
        for (int n = 0; n < 4; n++) begin
          if (m[n]) begin
            send(T_GETS, n, 0, 0);
            expect_msg("R2 gets", K_DATA, n, 0, 0, mem0, 0, 0);
          end
        end
        inv = m & ~(1 << r);
        cnt = 0;
        for (int n = 0; n < 4; n++) cnt += inv[n];
        send(T_GETM, r, 0, 0);
        expect_msg("R4 getm in S", K_DATA, r, 0, 0, mem0, inv, cnt);
        mem0 = (m * 16 + r * 3 + 1) & 255;
        send(T_PUTM, r, 0, mem0);
        expect_msg("R7 putm owner", K_ACK, r, 0, 0, 0, 0, 0);
      end
    end
    // R4: Get-M to a line in I
    send(T_GETM, 1, 0, 0);
    expect_msg("R4 getm in I", K_DATA, 1, 0, 0, mem0, 0, 0);
    // R5: chained Get-M forwards
    send(T_GETM, 2, 0, 0);
    expect_msg("R5 fwdm 1", K_FWDM, 1, 2, 0, 0, 0, 0);
    send(T_GETM, 3, 0, 0);
    expect_msg("R5 fwdm 2", K_FWDM, 2, 3, 0, 0, 0, 0);
    send(T_PUTM, 3, 0, 8'hC3);
    expect_msg("R7 putm new owner", K_ACK, 3, 0, 0, 0, 0, 0);
    send(T_GETS, 0, 0, 0);
    expect_msg("R7 data written", K_DATA, 0, 0, 0, 8'hC3, 0, 0);

    // R6 R10: forwarded read, held request, owner data release
    send(T_GETM, 2, 1, 0);
    expect_msg("R6 setup", K_DATA, 2, 0, 1, 0, 0, 0);
    send(T_GETS, 0, 1, 0);
    expect_msg("R6 fwds", K_FWDS, 2, 0, 1, 0, 0, 0);
    @(negedge clk);
    req_valid = 1; req_type = 2'(T_GETS); req_src = 2'd3; req_line = 2'd1;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk(req_ready == 0, "R10 held", int'(req_ready), 0);
      chk(out_valid == 0, "R10 no msg", int'(out_valid), 0);
      @(negedge clk);
    end
    odat_valid = 1; odat_line = 2'd1; odat_data = 8'h5A;
    #1;
    chk(odat_ready == 1, "R10 odat taken during hold", int'(odat_ready), 1);
    @(posedge clk); #1;
    odat_valid = 0;
    @(negedge clk); #1;
    chk(req_ready == 1, "R10 released", int'(req_ready), 1);
    @(posedge clk); #1;
    req_valid = 0;
    expect_msg("R6 data after owner", K_DATA, 3, 0, 1, 8'h5A, 0, 0);
    send(T_GETM, 1, 1, 0);
    expect_msg("R6 sharers old owner and reader", K_DATA, 1, 0, 1, 8'h5A, 4'b1101, 3);

    // R9: writeback crossing a forwarded read, late owner data ignored
    send(T_GETM, 1, 2, 0);
    expect_msg("R9 setup", K_DATA, 1, 0, 2, 0, 0, 0);
    send(T_GETS, 0, 2, 0);
    expect_msg("R9 fwds", K_FWDS, 1, 0, 2, 0, 0, 0);
    send(T_PUTM, 1, 2, 8'h33);
    expect_msg("R9 putack", K_ACK, 1, 0, 2, 0, 0, 0);
    owner_data(2, 8'h77);
    send(T_GETS, 3, 2, 0);
    expect_msg("R9 data kept", K_DATA, 3, 0, 2, 8'h33, 0, 0);
    send(T_GETM, 3, 2, 0);
    expect_msg("R9 settled S", K_DATA, 3, 0, 2, 8'h33, 4'b0011, 2);

    // R8: stale writeback from a non-owner
    send(T_GETM, 0, 3, 0);
    expect_msg("R8 setup", K_DATA, 0, 0, 3, 0, 0, 0);
    send(T_PUTM, 2, 3, 8'h99);
    expect_msg("R8 putack", K_ACK, 2, 0, 3, 0, 0, 0);
    send(T_GETS, 1, 3, 0);
    expect_msg("R8 owner unchanged", K_FWDS, 0, 1, 3, 0, 0, 0);
    owner_data(3, 8'h44);
    send(3, 2, 3, 0);
    expect_msg("R8 R2 data not overwritten", K_DATA, 2, 0, 3, 8'h44, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule